// File: doc/BRIEF.md
# Multiplexed Dot-Matrix LCD Scan Controller

This block refreshes a dot-matrix LCD panel of up to 80 segment columns by 16 common rows. It uses direct memory access. One row period after another, it reads the ten 8-bit words that hold the next row's pixels from a display RAM through a one-cycle-latency read port. It keeps them in a shadow buffer and presents them on the segment outputs at the row boundary. At the same boundary it selects the matching common line. A polarity signal changes at the end of every frame so that the panel sees alternating drive.

Software configures the block through an 8-bit mode word and a 4-bit control word. The mode word sets the row rate, the duty and how many segment groups are active. The control word holds the display on/off bit and the divider-resistor current enable. Two more inputs tell the block which clock source feeds it and which power mode the chip is in. On the main clock the display survives idle mode and is blanked in stop mode. On the subsystem clock it keeps scanning in both modes.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: While scanning, `com_sel` is one-hot and moves to the next row once every P clock cycles. P = BASE_DIV * 2^s, where s = {mode_word[7], mode_word[1:0]} read as a 3-bit number (BASE_DIV defaults to 12).
- R2: mode_word[2] picks the duty. 0 scans rows 0..7 and 1 scans rows 0..15, each wrapping back to row 0.
- R3: During each row period the block issues exactly 10 reads, at `ram_addr` = {row[3:0], word[3:0]} for words 0..9 of the row shown next. Data returns on `ram_rdata` one cycle after a read. Bit b of word w drives segment 8*w+b.
- R4: `seg_out` changes only at a row boundary, together with `com_sel`.
- R5: mode_word[6:3] gives the number of active 8-segment groups. A value of 1..10 enables that many groups from segment 0 upward, and 0 or any value above 10 enables all 80. Segments in inactive groups are 0.
- R6: `frame_pol` inverts at the boundary where row 0 is shown again after a full frame. It is 0 while the display is blanked.
- R7: With ctrl_word[0]=0, or after reset, `com_sel`, `seg_out` and `frame_pol` are 0 and no reads are issued. The scan restarts at row 0 when display is enabled again. `bias_en` is ctrl_word[1] while scanning and 0 otherwise.
- R8: With `sub_clk_sel`=0 the display scans in run (`pwr_mode`=0) and idle (1), and is blanked in stop (2). With `sub_clk_sel`=1 it scans in all three modes.
- R9: The first row (row 0) appears exactly P cycles after scanning is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_word | input | 8 | Rate (bits 7,1:0), duty (bit 2), active groups (bits 6:3) |
| ctrl_word | input | 4 | Bit 0 display on, bit 1 resistor current on, bits 3:2 unused |
| sub_clk_sel | input | 1 | 1 when clocked from the subsystem clock |
| pwr_mode | input | 2 | 0 run, 1 idle, 2 stop |
| ram_rdata | input | 8 | Display RAM read data, one cycle after `ram_rd` |
| ram_rd | output | 1 | Display RAM read strobe |
| ram_addr | output | 8 | Display RAM address {row, word} |
| com_sel | output | 16 | One-hot common select |
| seg_out | output | 80 | Segment data of the shown row |
| frame_pol | output | 1 | Frame polarity |
| bias_en | output | 1 | Divider-resistor current enable |

## Verification
If the row counter is wrong, the very next boundary shows a bad `com_sel` index or a bad frame wrap. A shadow buffer filled from the wrong word or address shows up as wrong `seg_out` bits when that row is shown, one period after the fetch. A period counter that is off changes the spacing between common changes, so the first boundary after enable exposes it. A polarity or blanking fault appears at the first frame wrap or within one cycle of the stop/disable input.

// File: rtl/lcd_scan_pkg.sv
// Shared definitions for the LCD scan controller.
// Assumes: the RAM word width is 8 bits and the panel has at most 16 commons.
package lcd_scan_pkg;
    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_IDLE = 2'd1,
        PWR_STOP = 2'd2
    } pwr_mode_e;

    localparam int unsigned WORD_W = 8;
    localparam int unsigned ROW_W  = 4;
endpackage

// File: rtl/lcd_row_timer.sv
// Row period counter: counts one row period of BASE_DIV << shift cycles and
// pulses row_tick in the last cycle of each period.
// Assumes: the counter is held at 0 while the scan is stopped.
module lcd_row_timer #(
    parameter int unsigned BASE_DIV = 12,
    parameter int unsigned SHIFT_W  = 3,
    parameter int unsigned CNT_W    = $clog2((BASE_DIV << ((1 << SHIFT_W) - 1)) + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SHIFT_W-1:0] shift,
    output logic [CNT_W-1:0]   pcnt,
    output logic               row_tick
);
    logic [CNT_W-1:0] period;

    // Period length for the selected rate.
    always_comb period = CNT_W'(BASE_DIV) << shift;

    assign row_tick = run && (pcnt >= period - CNT_W'(1));

    // Advance the period counter, restart at each boundary or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || row_tick) pcnt <= '0;
        else                            pcnt <= pcnt + CNT_W'(1);
    end

    // R1
    tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_tick |=> (pcnt == '0));
endmodule

// File: rtl/lcd_fetch.sv
// Row fetcher: during the first WORDS cycles of each row period it reads the
// words of the row to show next and stores them in a shadow buffer.
// Assumes: the RAM returns data one cycle after the read strobe, and the
// period is at least WORDS+2 cycles long.
module lcd_fetch
    import lcd_scan_pkg::*;
#(
    parameter int unsigned WORDS  = 10,
    parameter int unsigned CNT_W  = 11,
    localparam int unsigned WIDX_W = $clog2(WORDS),
    localparam int unsigned SEGS   = WORDS * WORD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic [CNT_W-1:0]        pcnt,
    input  logic [ROW_W-1:0]        fetch_row,
    input  logic [WORD_W-1:0]       ram_rdata,
    output logic                    ram_rd,
    output logic [ROW_W+WIDX_W-1:0] ram_addr,
    output logic [SEGS-1:0]         shadow
);
    logic              cap_v;
    logic [WIDX_W-1:0] cap_w;

    assign ram_rd   = run && (pcnt < CNT_W'(WORDS));
    assign ram_addr = {fetch_row, pcnt[WIDX_W-1:0]};

    // Remember which word returns on the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_v <= 1'b0;
            cap_w <= '0;
        end else begin
            cap_v <= ram_rd;
            cap_w <= pcnt[WIDX_W-1:0];
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // Store the returned word into its slot of the shadow buffer.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  shadow[g*WORD_W +: WORD_W] <= '0;
            else if (cap_v && cap_w == WIDX_W'(g))       shadow[g*WORD_W +: WORD_W] <= ram_rdata;
        end
    end

    // R3
    fetch_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd |-> (ram_addr[WIDX_W-1:0] < WIDX_W'(WORDS)));
    // R3
    fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !ram_rd);
endmodule

// File: rtl/lcd_row_seq.sv
// Row sequencer: at each boundary presents the shadow row (masked to the
// active groups), selects its common line, advances the row index with the
// selected duty and flips polarity when a frame wraps.
// Assumes: row_tick only pulses while run is high.
module lcd_row_seq
    import lcd_scan_pkg::*;
#(
    parameter int unsigned WORDS = 10,
    parameter int unsigned COMS  = 16,
    localparam int unsigned SEGS  = WORDS * WORD_W,
    localparam int unsigned GRP_W = $clog2(WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             row_tick,
    input  logic             duty16,
    input  logic [3:0]       grp_field,
    input  logic [SEGS-1:0]  shadow,
    output logic [ROW_W-1:0] next_row,
    output logic [COMS-1:0]  com_sel,
    output logic [SEGS-1:0]  seg_out,
    output logic             frame_pol
);
    logic [GRP_W-1:0] groups;
    logic [SEGS-1:0]  mask;
    logic [ROW_W-1:0] last_row;
    logic             shown;

    // Number of active groups; zero or out of range means all of them.
    always_comb begin
        if (grp_field == 4'd0 || 32'(grp_field) > WORDS) groups = GRP_W'(WORDS);
        else                                             groups = GRP_W'(grp_field);
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_mask
        assign mask[g*WORD_W +: WORD_W] = {WORD_W{GRP_W'(g) < groups}};
    end

    // Last row index for the chosen duty.
    always_comb last_row = duty16 ? ROW_W'(COMS - 1) : ROW_W'(COMS / 2 - 1);

    // Present the fetched row at each boundary; blank everything when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            next_row  <= '0;
            com_sel   <= '0;
            seg_out   <= '0;
            frame_pol <= 1'b0;
            shown     <= 1'b0;
        end else if (row_tick) begin
            com_sel   <= COMS'(1) << next_row;
            seg_out   <= shadow & mask;
            next_row  <= (next_row >= last_row) ? '0 : next_row + ROW_W'(1);
            frame_pol <= frame_pol ^ (shown && next_row == '0);
            shown     <= 1'b1;
        end
    end

    // R1
    com_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(com_sel));
    // R4
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !row_tick) |=> $stable(seg_out));
    // R6
    pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !row_tick) |=> $stable(frame_pol));
    // R2
    row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !duty16 && $stable(duty16)) |=> (next_row < ROW_W'(COMS / 2)));
endmodule

// File: rtl/lcd_scan_ctrl.sv
// Top of the LCD scan controller: decodes mode and control words, decides
// from clock source and power mode whether the scan runs, and ties the row
// timer, the RAM fetcher and the row sequencer together.
// Assumes: BASE_DIV >= WORDS + 2 so a row is fetched before it is shown.
module lcd_scan_ctrl
    import lcd_scan_pkg::*;
#(
    parameter int unsigned BASE_DIV = 12,
    parameter int unsigned WORDS    = 10,
    parameter int unsigned COMS     = 16,
    localparam int unsigned SEGS    = WORDS * WORD_W,
    localparam int unsigned WIDX_W  = $clog2(WORDS),
    localparam int unsigned CNT_W   = $clog2((BASE_DIV << 7) + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              mode_word,
    input  logic [3:0]              ctrl_word,
    input  logic                    sub_clk_sel,
    input  logic [1:0]              pwr_mode,
    input  logic [WORD_W-1:0]       ram_rdata,
    output logic                    ram_rd,
    output logic [ROW_W+WIDX_W-1:0] ram_addr,
    output logic [COMS-1:0]         com_sel,
    output logic [SEGS-1:0]         seg_out,
    output logic                    frame_pol,
    output logic                    bias_en
);
    logic             run;
    logic             row_tick;
    logic [CNT_W-1:0] pcnt;
    logic [ROW_W-1:0] next_row;
    logic [SEGS-1:0]  shadow;

    // Scan runs when enabled and not stopped on the main clock.
    always_comb run = ctrl_word[0] && !(pwr_mode == PWR_STOP && !sub_clk_sel);

    // Resistor current follows the control bit only while scanning.
    always_ff @(posedge clk) begin
        if (!rst_n) bias_en <= 1'b0;
        else        bias_en <= run && ctrl_word[1];
    end

    lcd_row_timer #(.BASE_DIV(BASE_DIV), .SHIFT_W(3), .CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .shift    ({mode_word[7], mode_word[1:0]}),
        .pcnt     (pcnt),
        .row_tick (row_tick)
    );

    lcd_fetch #(.WORDS(WORDS), .CNT_W(CNT_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .pcnt      (pcnt),
        .fetch_row (next_row),
        .ram_rdata (ram_rdata),
        .ram_rd    (ram_rd),
        .ram_addr  (ram_addr),
        .shadow    (shadow)
    );

    lcd_row_seq #(.WORDS(WORDS), .COMS(COMS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .row_tick  (row_tick),
        .duty16    (mode_word[2]),
        .grp_field (mode_word[6:3]),
        .shadow    (shadow),
        .next_row  (next_row),
        .com_sel   (com_sel),
        .seg_out   (seg_out),
        .frame_pol (frame_pol)
    );

    // R7
    off_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_word[0] |=> (com_sel == '0 && seg_out == '0 && !frame_pol));
    // R8
    stop_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == PWR_STOP && !sub_clk_sel) |=> (com_sel == '0 && !bias_en));
endmodule

// File: tb/lcd_scan_ctrl_tb.sv
module lcd_scan_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mode_word = '0;
    logic [3:0]  ctrl_word = '0;
    logic        sub_clk_sel = 1'b0;
    logic [1:0]  pwr_mode = '0;
    logic [7:0]  ram_rdata = '0;
    logic        ram_rd;
    logic [7:0]  ram_addr;
    logic [15:0] com_sel;
    logic [79:0] seg_out;
    logic        frame_pol;
    logic        bias_en;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_cyc = 0;
    int exp_period = 12;
    int rd_cnt = 0;
    logic [15:0] prev_com = '0;
    logic [79:0] prev_seg = '0;
    logic [96:0] exp_q[$];

    always #2 clk = ~clk;

    lcd_scan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .ctrl_word(ctrl_word),
        .sub_clk_sel(sub_clk_sel), .pwr_mode(pwr_mode), .ram_rdata(ram_rdata),
        .ram_rd(ram_rd), .ram_addr(ram_addr), .com_sel(com_sel), .seg_out(seg_out),
        .frame_pol(frame_pol), .bias_en(bias_en)
    );

    function automatic logic [7:0] pix(input int r, input int w);
        return 8'((r * 37 + w * 11 + 5) ^ (r << 4));
    endfunction

    // Display RAM model with one-cycle read latency; counts reads.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ram_rd) begin
            ram_rdata <= pix(int'(ram_addr[7:4]), int'(ram_addr[3:0]));
            rd_cnt = rd_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pop expected rows as the design presents them.
    always @(negedge clk) begin
        if (rst_n) begin
            if (com_sel != prev_com && com_sel != '0) begin
                if (exp_q.size() == 0) begin
                    check("R1 unexpected row", 128'(com_sel), 128'(0));
                end else begin
                    logic [96:0] it;
                    it = exp_q.pop_front();
                    check("R1/R2 common", 128'(com_sel), 128'(it[96:81]));
                    check("R3/R5 segments", 128'(seg_out), 128'(it[80:1]));
                    check("R6 polarity", 128'(frame_pol), 128'(it[0]));
                    check("R1/R9 period", 128'(cyc - last_cyc), 128'(exp_period));
                    check("R3 reads per row", 128'(rd_cnt), 128'(10));
                end
                last_cyc = cyc;
                rd_cnt = 0;
            end else if (com_sel == prev_com && com_sel != '0 && seg_out != prev_seg) begin
                check("R4 mid-row segment change", 128'(seg_out), 128'(prev_seg));
            end
            prev_com = com_sel;
            prev_seg = seg_out;
        end
    end

    task automatic configure(input int shift, input bit d16, input int grp,
                             input bit sub, input logic [1:0] pm);
        @(negedge clk);
        mode_word   = {1'(shift >> 2), 4'(grp), d16, 2'(shift)};
        sub_clk_sel = sub;
        pwr_mode    = pm;
        exp_period  = 12 << shift;
    endtask

    // Driver: push the expected rows for a scan starting at row 0.
    task automatic expect_rows(input int n, input bit d16, input int grp);
        int nrows = d16 ? 16 : 8;
        int eg = (grp == 0 || grp > 10) ? 10 : grp;
        for (int k = 0; k < n; k++) begin
            int r = k % nrows;
            logic [79:0] s = '0;
            for (int w = 0; w < eg; w++) s[w*8 +: 8] = pix(r, w);
            exp_q.push_back({16'(1) << r, s, 1'((k / nrows) % 2)});
        end
    endtask

    task automatic start_scan(input logic [3:0] cw, input logic [1:0] pm);
        @(negedge clk);
        ctrl_word = cw;
        pwr_mode = pm;
        last_cyc = cyc;
        rd_cnt = 0;
    endtask

    task automatic check_blank(input string req);
        @(negedge clk);
        @(negedge clk);
        check(req, 128'(com_sel), 128'(0));
        check(req, 128'(seg_out), 128'(0));
        check(req, 128'(frame_pol), 128'(0));
        check(req, 128'(ram_rd), 128'(0));
    endtask

    task automatic finish_run(input int n, input string req);
        repeat (n * exp_period + 2) @(negedge clk);
        check(req, 128'(exp_q.size()), 128'(0));
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7 reset state
        @(negedge clk);
        check("R7 reset com", 128'(com_sel), 128'(0));
        check("R7 reset seg", 128'(seg_out), 128'(0));
        check("R7 reset pol", 128'(frame_pol), 128'(0));
        check("R7 reset bias", 128'(bias_en), 128'(0));

        // R1 R2 R3 R5 R6 R9: 1/16 duty, all groups, fastest rate
        configure(0, 1'b1, 0, 1'b0, 2'd0);
        expect_rows(20, 1'b1, 0);
        start_scan(4'b0011, 2'd0);
        repeat (3) @(negedge clk);
        check("R7 bias on", 128'(bias_en), 128'(1));
        finish_run(20, "R1 rows consumed");
        ctrl_word = 4'b0000;
        check_blank("R7 display off");

        // R2 R5 R8: 1/8 duty, 5 groups, idle on main clock, resistor off
        configure(1, 1'b0, 5, 1'b0, 2'd1);
        expect_rows(12, 1'b0, 5);
        start_scan(4'b0001, 2'd1);
        repeat (3) @(negedge clk);
        check("R7 bias follows ctrl", 128'(bias_en), 128'(0));
        finish_run(12, "R8 idle main keeps scanning");
        ctrl_word = 4'b0000;
        check_blank("R7 display off");

        // R8 R1: subsystem clock in stop keeps scanning; slow rate; group field 12
        configure(4, 1'b1, 12, 1'b1, 2'd2);
        expect_rows(17, 1'b1, 12);
        start_scan(4'b0011, 2'd2);
        finish_run(17, "R8 stop on sub clock keeps scanning");
        ctrl_word = 4'b0000;
        check_blank("R7 display off");

        // R8 R7: stop on main clock blanks, restart from row 0
        configure(0, 1'b0, 3, 1'b0, 2'd0);
        expect_rows(5, 1'b0, 3);
        start_scan(4'b0011, 2'd0);
        finish_run(5, "R8 run before stop");
        pwr_mode = 2'd2;
        check_blank("R8 stop on main clock");
        check("R8 bias off in stop", 128'(bias_en), 128'(0));
        expect_rows(10, 1'b0, 3);
        start_scan(4'b0011, 2'd1);
        finish_run(10, "R7 restart at row 0");

        // R7: disable in the middle of a row
        repeat (5) @(negedge clk);
        ctrl_word = 4'b0010;
        check_blank("R7 disable mid-row");
        check("R7 bias off when disabled", 128'(bias_en), 128'(0));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule